// File: doc/BRIEF.md
# Multilevel feedback queue scheduler

This block decides, cycle by cycle, which of a small set of processes owns a single execution resource. Time is counted in clock cycles: every cycle the running process consumes one unit of its current CPU burst. Ready processes wait in four priority levels. The top three levels are round-robin levels, each with its own quantum. The lowest level is served in arrival order with no quantum.

A process is announced once on the arrival port with its ID, a regular/batch flag, a burst length and a burst count. All bursts of a process have the same length. A process whose quantum runs out drops one level. A process that finishes a burst other than its last waits in a blocked pool for a programmable delay and then re-enters the top level. A process that finishes its last burst is retired with a one-cycle completion pulse. A mode input selects priority-preemptive or non-preemptive dispatch, and can be changed while the block runs.

Top module: `mlfq_sched`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `run_valid` and `done_valid` are 0, and every process slot is idle.
- R2: An arrival is accepted on the clock edge where `arr_valid` is 1, but only if that ID is idle and both `arr_burst` and `arr_count` are nonzero. Otherwise it has no effect. An accepted regular process (`arr_batch`=0) joins level 1, the highest. An accepted batch process (`arr_batch`=1) joins level 4, the lowest. If nothing is running, the new process is dispatched on that same edge.
- R3: On each dispatch the block takes the head of the highest non-empty level. Within a level, processes leave in the order they joined it.
- R4: At levels 1, 2 and 3, the quantum is `cfg_quantum1`, `cfg_quantum2` and `cfg_quantum3`. A process that uses its whole quantum without ending its burst moves down one level and joins the tail. A process at level 4 is never stopped by a quantum.
- R5: With `cfg_preempt`=1, a running process is put back at the tail of its own level, keeping its remaining burst, when a process at a strictly higher level becomes ready. The higher process is dispatched on that same edge.
- R6: With `cfg_preempt`=0, a running process keeps the resource until its quantum expires or its burst ends, whatever becomes ready meanwhile.
- R7: A process that ends a burst other than its last is blocked for `cfg_io_delay` cycles (a value of 0 acts as 1). It then becomes ready at level 1 with a fresh burst of the same length.
- R8: A process that ends its last burst becomes idle. On the next cycle `done_valid` is 1 for exactly one cycle and `done_id` holds its ID.
- R9: Events on the same edge are applied in this order: I/O returns (lowest ID first), then the arrival, then the re-queue of the running process, then dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one time unit |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_preempt | input | 1 | 1 = priority-preemptive, 0 = non-preemptive |
| cfg_quantum1 | input | QT_W | Quantum of level 1 |
| cfg_quantum2 | input | QT_W | Quantum of level 2 |
| cfg_quantum3 | input | QT_W | Quantum of level 3 |
| cfg_io_delay | input | IO_W | Cycles spent blocked between bursts |
| arr_valid | input | 1 | Arrival strobe |
| arr_id | input | ID_W | Arriving process ID |
| arr_batch | input | 1 | 1 = batch, 0 = regular |
| arr_burst | input | BURST_W | Length of every burst of the process |
| arr_count | input | CNT_W | Number of bursts |
| run_valid | output | 1 | A process holds the resource |
| run_id | output | ID_W | ID of the running process |
| done_valid | output | 1 | One-cycle retirement pulse |
| done_id | output | ID_W | ID of the retired process |

## Verification
The hardest case to reach is a single edge on which several ordering rules act at once. For example, an I/O return and a new arrival both land in level 1 while the resource is idle, or a quantum expiry and a batch arrival meet in different levels. The stimulus reaches these edges by choosing burst lengths, a short I/O delay and short quanta so the events line up on one cycle, and then observes which ID is dispatched first. The mode switch is exercised by reusing retired IDs in a second phase with preemption turned off. A further run with the larger quanta checks round-robin rotation and demotion between two long regular jobs.

// File: rtl/mlfq_sched.sv
module mlfq_sched #(
  parameter int NPROC   = 4,
  parameter int BURST_W = 8,
  parameter int CNT_W   = 4,
  parameter int QT_W    = 4,
  parameter int IO_W    = 4,
  localparam int ID_W   = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_preempt,
  input  logic [QT_W-1:0]    cfg_quantum1,
  input  logic [QT_W-1:0]    cfg_quantum2,
  input  logic [QT_W-1:0]    cfg_quantum3,
  input  logic [IO_W-1:0]    cfg_io_delay,
  input  logic               arr_valid,
  input  logic [ID_W-1:0]    arr_id,
  input  logic               arr_batch,
  input  logic [BURST_W-1:0] arr_burst,
  input  logic [CNT_W-1:0]   arr_count,
  output logic               run_valid,
  output logic [ID_W-1:0]    run_id,
  output logic               done_valid,
  output logic [ID_W-1:0]    done_id
);
  localparam logic [1:0] P_IDLE = 2'd0, P_READY = 2'd1, P_RUN = 2'd2, P_BLK = 2'd3;
  localparam logic [1:0] LV_TOP = 2'd0, LV_BOT = 2'd3;

  logic [NPROC-1:0][1:0]         st_q, st_n, lv_q, lv_n;
  logic [NPROC-1:0][BURST_W-1:0] rem_q, rem_n, len_q, len_n;
  logic [NPROC-1:0][CNT_W-1:0]   left_q, left_n;
  logic [NPROC-1:0][IO_W-1:0]    io_q, io_n;
  logic [NPROC-1:0][NPROC-1:0]   ord_q, ord_n;   // ord[i][j]: i joined its queue before j
  logic [QT_W-1:0]               used_q, used_n;
  logic                          rv_n, dv_n, keep, found, higher, is_head;
  logic [ID_W-1:0]               rid_n, did_n, pick;
  logic [1:0]                    best;
  logic [QT_W-1:0]               qcur;
  logic [IO_W-1:0]               io_load;

  always_comb
    case (lv_q[run_id])
      2'd0:    qcur = cfg_quantum1;
      2'd1:    qcur = cfg_quantum2;
      default: qcur = cfg_quantum3;
    endcase

  assign io_load = (cfg_io_delay == '0) ? IO_W'(1) : cfg_io_delay;

  always_comb begin
    st_n = st_q; lv_n = lv_q; rem_n = rem_q; len_n = len_q;
    left_n = left_q; io_n = io_q; ord_n = ord_q;
    used_n = '0; rv_n = 1'b0; rid_n = run_id; dv_n = 1'b0; did_n = done_id;
    keep = 1'b0; found = 1'b0; higher = 1'b0; is_head = 1'b0;
    best = LV_BOT; pick = '0;

    for (int i = 0; i < NPROC; i++)
      if (st_q[i] == P_BLK) begin
        if (io_q[i] == IO_W'(1)) begin
          st_n[i] = P_READY;
          lv_n[i] = LV_TOP;
          for (int j = 0; j < NPROC; j++)
            if (j != i) begin ord_n[i][j] = 1'b0; ord_n[j][i] = 1'b1; end
        end else
          io_n[i] = io_q[i] - IO_W'(1);
      end

    if (arr_valid && st_q[arr_id] == P_IDLE && arr_burst != '0 && arr_count != '0) begin
      st_n[arr_id]   = P_READY;
      lv_n[arr_id]   = arr_batch ? LV_BOT : LV_TOP;
      rem_n[arr_id]  = arr_burst;
      len_n[arr_id]  = arr_burst;
      left_n[arr_id] = arr_count;
      for (int j = 0; j < NPROC; j++)
        if (j != int'(arr_id)) begin ord_n[arr_id][j] = 1'b0; ord_n[j][arr_id] = 1'b1; end
    end

    if (run_valid) begin
      if (rem_q[run_id] == BURST_W'(1)) begin
        if (left_q[run_id] == CNT_W'(1)) begin
          st_n[run_id] = P_IDLE;
          dv_n = 1'b1;
          did_n = run_id;
        end else begin
          st_n[run_id]   = P_BLK;
          io_n[run_id]   = io_load;
          rem_n[run_id]  = len_q[run_id];
          left_n[run_id] = left_q[run_id] - CNT_W'(1);
        end
      end else begin
        rem_n[run_id] = rem_q[run_id] - BURST_W'(1);
        for (int i = 0; i < NPROC; i++)
          if (st_n[i] == P_READY && lv_n[i] < lv_q[run_id]) higher = 1'b1;
        if (lv_q[run_id] != LV_BOT && ({1'b0, used_q} + 1'b1) >= {1'b0, qcur}) begin
          lv_n[run_id] = lv_q[run_id] + 2'd1;
          st_n[run_id] = P_READY;
        end else if (cfg_preempt && higher)
          st_n[run_id] = P_READY;
        else
          keep = 1'b1;
        if (!keep)
          for (int j = 0; j < NPROC; j++)
            if (j != int'(run_id)) begin ord_n[run_id][j] = 1'b0; ord_n[j][run_id] = 1'b1; end
      end
    end

    if (keep) begin
      rv_n = 1'b1;
      used_n = used_q + QT_W'(1);
    end else begin
      for (int i = 0; i < NPROC; i++)
        if (st_n[i] == P_READY && (!found || lv_n[i] < best)) begin
          found = 1'b1;
          best = lv_n[i];
        end
      for (int i = 0; i < NPROC; i++)
        if (st_n[i] == P_READY && lv_n[i] == best) begin
          is_head = 1'b1;
          for (int j = 0; j < NPROC; j++)
            if (j != i && st_n[j] == P_READY && lv_n[j] == best && !ord_n[i][j]) is_head = 1'b0;
          if (is_head) pick = ID_W'(i);
        end
      if (found) begin
        rv_n = 1'b1;
        rid_n = pick;
        st_n[pick] = P_RUN;
      end
    end
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      st_q <= '0; lv_q <= '0; rem_q <= '0; len_q <= '0; left_q <= '0;
      io_q <= '0; ord_q <= '0; used_q <= '0;
      run_valid <= 1'b0; run_id <= '0; done_valid <= 1'b0; done_id <= '0;
    end else begin
      st_q <= st_n; lv_q <= lv_n; rem_q <= rem_n; len_q <= len_n; left_q <= left_n;
      io_q <= io_n; ord_q <= ord_n; used_q <= used_n;
      run_valid <= rv_n; run_id <= rid_n; done_valid <= dv_n; done_id <= did_n;
    end

  logic [NPROC-1:0] run_mask;
  logic             higher_q;
  always_comb begin
    higher_q = 1'b0;
    for (int i = 0; i < NPROC; i++) begin
      run_mask[i] = (st_q[i] == P_RUN);
      if (st_q[i] == P_READY && lv_q[i] < lv_q[run_id]) higher_q = 1'b1;
    end
  end

  a_r3_single_runner: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(run_mask) == (run_valid ? 1 : 0));
  a_r5_no_higher_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_preempt) && run_valid) |-> !higher_q);
  a_r4_quantum_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run_valid && lv_q[run_id] != LV_BOT) |-> (used_q < qcur));
  a_r8_done_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> ($past(run_valid) && done_id == $past(run_id)));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !(done_valid && $stable(done_id)));

  for (genvar g = 0; g < NPROC; g++) begin : g_chk
    a_r7_block_count: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == P_BLK) |-> (io_q[g] != '0));
  end
endmodule

// File: tb/mlfq_sched_bench.sv
`timescale 1ns/1ps
module mlfq_sched_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cfg_preempt = 1'b1;
  logic [3:0] cfg_quantum1 = 4'd2, cfg_quantum2 = 4'd2, cfg_quantum3 = 4'd2, cfg_io_delay = 4'd3;
  logic       arr_valid = 1'b0, arr_batch = 1'b0;
  logic [1:0] arr_id = '0;
  logic [7:0] arr_burst = '0;
  logic [3:0] arr_count = '0;
  logic       run_valid, done_valid;
  logic [1:0] run_id, done_id;
  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  mlfq_sched u_mlfq_sched (
    .clk(clk), .rst_n(rst_n), .cfg_preempt(cfg_preempt),
    .cfg_quantum1(cfg_quantum1), .cfg_quantum2(cfg_quantum2), .cfg_quantum3(cfg_quantum3),
    .cfg_io_delay(cfg_io_delay), .arr_valid(arr_valid), .arr_id(arr_id),
    .arr_batch(arr_batch), .arr_burst(arr_burst), .arr_count(arr_count),
    .run_valid(run_valid), .run_id(run_id), .done_valid(done_valid), .done_id(done_id));

  // {req, mode, av, id, batch, burst, count, exp rv, exp run id, exp dv, exp done id}
  localparam logic [20:0] TBL [0:31] = '{
    {4'd2,1'b1,1'b1,2'd0,1'b0,4'd3,2'd2, 1'b1,2'd0,1'b0,2'd0}, // R2 regular enters
    {4'd4,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b1,2'd0,1'b0,2'd0}, // R4
    {4'd4,1'b1,1'b1,2'd1,1'b1,4'd2,2'd1, 1'b1,2'd0,1'b0,2'd0}, // R4 demote beats batch
    {4'd7,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b1,2'd1,1'b0,2'd0}, // R7 id0 blocks
    {4'd4,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b1,2'd1,1'b0,2'd0}, // R4 level 4
    {4'd8,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b0,2'd0,1'b1,2'd1}, // R8
    {4'd7,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b1,2'd0,1'b0,2'd0}, // R7 return
    {4'd3,1'b1,1'b1,2'd2,1'b0,4'd1,2'd1, 1'b1,2'd0,1'b0,2'd0}, // R3 same level no preempt
    {4'd3,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b1,2'd2,1'b0,2'd0}, // R3
    {4'd8,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b1,2'd0,1'b1,2'd2}, // R8
    {4'd8,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b0,2'd0,1'b1,2'd0}, // R8
    {4'd8,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b0,2'd0,1'b0,2'd0}, // R8 one cycle pulse
    {4'd2,1'b1,1'b1,2'd3,1'b1,4'd4,2'd1, 1'b1,2'd3,1'b0,2'd0}, // R2 batch enters
    {4'd5,1'b1,1'b1,2'd1,1'b0,4'd2,2'd1, 1'b1,2'd1,1'b0,2'd0}, // R5 preempt
    {4'd5,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b1,2'd1,1'b0,2'd0}, // R5
    {4'd5,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b1,2'd3,1'b1,2'd1}, // R5 resumes
    {4'd5,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b1,2'd3,1'b0,2'd0}, // R5
    {4'd5,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b1,2'd3,1'b0,2'd0}, // R5
    {4'd5,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b0,2'd0,1'b1,2'd3}, // R5 burst kept
    {4'd6,1'b0,1'b1,2'd3,1'b1,4'd3,2'd1, 1'b1,2'd3,1'b0,2'd0}, // R6
    {4'd6,1'b0,1'b1,2'd0,1'b0,4'd1,2'd1, 1'b1,2'd3,1'b0,2'd0}, // R6 no preempt
    {4'd6,1'b0,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b1,2'd3,1'b0,2'd0}, // R6
    {4'd6,1'b0,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b1,2'd0,1'b1,2'd3}, // R6
    {4'd6,1'b0,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b0,2'd0,1'b1,2'd0}, // R6
    {4'd6,1'b0,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b0,2'd0,1'b0,2'd0}, // R6
    {4'd7,1'b1,1'b1,2'd0,1'b0,4'd1,2'd2, 1'b1,2'd0,1'b0,2'd0}, // R7
    {4'd7,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b0,2'd0,1'b0,2'd0}, // R7 blocked
    {4'd7,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b0,2'd0,1'b0,2'd0}, // R7
    {4'd7,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b0,2'd0,1'b0,2'd0}, // R7
    {4'd9,1'b1,1'b1,2'd1,1'b0,4'd1,2'd1, 1'b1,2'd0,1'b0,2'd0}, // R9 return before arrival
    {4'd9,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b1,2'd1,1'b1,2'd0}, // R9
    {4'd8,1'b1,1'b0,2'd0,1'b0,4'd0,2'd0, 1'b0,2'd0,1'b1,2'd1}  // R8
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {run_valid, run_valid ? run_id : 2'd0, done_valid, done_valid ? done_id : 2'd0};
  endfunction

  task automatic tick_arr(input logic [1:0] id, input logic b, input logic [7:0] len, input logic [3:0] cnt);
    @(negedge clk);
    arr_valid = 1'b1; arr_id = id; arr_batch = b; arr_burst = len; arr_count = cnt;
    @(posedge clk); #1;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      arr_valid = 1'b0;
      @(posedge clk); #1;
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", "outputs in reset", 32'(outs()), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", "outputs after reset", 32'(outs()), 32'h0);

    for (int k = 0; k < 32; k++) begin
      logic [20:0] v;
      v = TBL[k];
      @(negedge clk);
      cfg_preempt = v[16]; arr_valid = v[15]; arr_id = v[14:13]; arr_batch = v[12];
      arr_burst = {4'b0, v[11:8]}; arr_count = {2'b0, v[7:6]};
      @(posedge clk); #1;
      check($sformatf("R%0d", v[20:17]), $sformatf("row %0d", k), 32'(outs()), 32'(v[5:0]));
    end

    @(negedge clk);
    arr_valid = 1'b0; rst_n = 1'b0;
    cfg_quantum1 = 4'd6; cfg_quantum2 = 4'd4; cfg_quantum3 = 4'd3; cfg_io_delay = 4'd5;
    cfg_preempt = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    tick_arr(2'd0, 1'b0, 8'd8, 4'd1);            // E0
    check("R2", "id0 dispatched", 32'(outs()), {26'd0, 6'b100000});
    tick_arr(2'd1, 1'b0, 8'd8, 4'd1);            // E1
    tick(1);                                     // E2
    tick_arr(2'd0, 1'b0, 8'd1, 4'd1);            // E3: id0 busy, ignored
    tick(2);                                     // E5
    check("R4", "id0 inside quantum 6", 32'(outs()), {26'd0, 6'b100000});
    tick(1);                                     // E6
    check("R4", "id0 demoted, id1 runs", 32'(outs()), {26'd0, 6'b101000});
    tick(6);                                     // E12
    check("R3", "level 2 head id0", 32'(outs()), {26'd0, 6'b100000});
    tick(2);                                     // E14
    check("R2", "ignored arrival left burst intact", 32'(outs()), {26'd0, 6'b101100});
    tick(2);                                     // E16
    check("R8", "id1 retired", 32'(outs()), {26'd0, 6'b000101});

    tick_arr(2'd2, 1'b1, 8'd9, 4'd1);
    check("R2", "batch id2 runs", 32'(outs()), {26'd0, 6'b110000});
    tick(2);
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1", "reset while running", 32'(outs()), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", "slots idle after reset", 32'(outs()), 32'h0);
    tick_arr(2'd2, 1'b0, 8'd1, 4'd1);
    check("R1", "id2 accepted again after reset", 32'(outs()), {26'd0, 6'b110000});
    tick(1);
    check("R8", "id2 retired after reset", 32'(outs()), {26'd0, 6'b000110});
    finish_run();
  end
endmodule